// File: doc/BRIEF.md
# Command-Queue Register Interface

This block is the software-facing register set of a host-to-controller DMA command queue. It decodes a 4 KiB window on a simple 32-bit register bus (valid, write, address, write data, read data), holds the queue limit, producer and consumer pointers, an interrupt enable register, an interrupt status register and a bank of general-purpose words, and drives one level interrupt. No data is moved; instead, every producer-pointer update stands in for a finished transfer. It mirrors the new pointer into the consumer pointer, sets both completion flags (one per direction) and, if enabled, raises the interrupt.

Software can veto exactly one such completion by first writing a fixed key to the consumer-pointer address. A parameter picks one of two register layouts, which differ in pointer offsets, in the enable/status offsets, in which status bits mean completion and in which enable bits are writable.

Top module: `cq_regif`

## Requirements
- R1: Reset drives irq low, clears every register and the suppression flag, and leaves the status register at 0xF8000000; after reset a producer-pointer write always completes.
- R2: A word address below 32 (byte address below 0x80) that is not one of the five special registers stores all 32 written bits; a read returns data on bus_rdata in the cycle after the request is accepted.
- R3: A byte address of 0x80 or more reads as zero, and a write there changes no register.
- R4: Writes to the limit pointer and producer pointer keep only bits [17:0]; the upper bits read as zero.
- R5: A producer-pointer write also loads the same masked value into the consumer pointer.
- R6: A write to the consumer-pointer address never changes its stored value.
- R7: A producer-pointer write that is not suppressed sets both completion bits in status (legacy bits 4 and 5, newer bits 16 and 17). It raises irq in the same cycle if either of those bits is set in the enable register.
- R8: The enable register stores the written value ANDed with 0xBFEFF07F (legacy) or 0x017003FF (newer).
- R9: A status write with any completion bit set clears both completion bits and drops irq; a status write with no completion bit set has no effect; non-completion status bits never change.
- R10: Writing exactly 0xEE882266 to the consumer-pointer address arms a flag. The next producer-pointer write then clears the flag and sets no status bit and no irq. Other values written there leave the flag unchanged.
- R11: irq is a registered level that, once high, stays high through enable-register writes, other writes and further completions until cleared by R9 or reset.
- R12: MAP_SEL=0 places limit/producer/consumer/enable/status at 0x14/0x18/0x1C/0x20/0x24. MAP_SEL=1 places them at 0x18/0x1C/0x20/0x38/0x3C, where 0x14 is an ordinary word and irq can never be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt for completion |

## Verification
The checker holds several rules on every cycle. Any rising irq must follow a producer-pointer write. A clearing status write must leave irq low. The consumer pointer must equal the producer pointer after a producer write and must hold still across consumer-address writes. Out-of-window reads must return zero, and the non-completion status bits must never move. Only the bench scenarios can show the rest: the one-shot veto and its survival across an ordinary consumer write, its loss at reset, the exact write masks of both layouts, and that the newer layout never raises irq even with every enable bit written.

// File: rtl/cq_regif_pkg.sv
package cq_regif_pkg;

  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int PTR_W   = 18;
  localparam int WORD_AW = ADDR_W - 2;

  localparam logic [DATA_W-1:0] ARM_KEY   = 32'hEE88_2266;
  localparam logic [DATA_W-1:0] STS_RESET = 32'hF800_0000;

  typedef enum logic [2:0] {
    K_NONE,
    K_PLAIN,
    K_LIMIT,
    K_PROD,
    K_CONS,
    K_ENA,
    K_STS
  } kind_e;

  typedef struct packed {
    logic [WORD_AW-1:0] limit_i;
    logic [WORD_AW-1:0] prod_i;
    logic [WORD_AW-1:0] cons_i;
    logic [WORD_AW-1:0] ena_i;
    logic [WORD_AW-1:0] sts_i;
    logic [DATA_W-1:0]  ena_mask;
    logic [DATA_W-1:0]  done_mask;
  } map_t;

  function automatic map_t map_of(input int sel);
    map_t m;
    if (sel == 0) begin
      m.limit_i   = WORD_AW'(5);
      m.prod_i    = WORD_AW'(6);
      m.cons_i    = WORD_AW'(7);
      m.ena_i     = WORD_AW'(8);
      m.sts_i     = WORD_AW'(9);
      m.ena_mask  = 32'hBFEF_F07F;
      m.done_mask = 32'h0000_0030;
    end else begin
      m.limit_i   = WORD_AW'(6);
      m.prod_i    = WORD_AW'(7);
      m.cons_i    = WORD_AW'(8);
      m.ena_i     = WORD_AW'(14);
      m.sts_i     = WORD_AW'(15);
      m.ena_mask  = 32'h0170_03FF;
      m.done_mask = 32'h0003_0000;
    end
    return m;
  endfunction

endpackage

// File: rtl/cq_rst_sync.sv
module cq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/cq_addr_decode.sv
module cq_addr_decode
  import cq_regif_pkg::*;
#(
  parameter int MAP_SEL   = 0,
  parameter int NUM_WORDS = 32
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic                         in_range,
  output logic [$clog2(NUM_WORDS)-1:0] idx,
  output kind_e                        kind
);

  localparam int   IDX_W = $clog2(NUM_WORDS);
  localparam map_t MAP   = map_of(MAP_SEL);

  logic [WORD_AW-1:0] word;
  logic [1:0]         unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];
  assign in_range   = (word < WORD_AW'(NUM_WORDS));
  assign idx        = word[IDX_W-1:0];

  always_comb begin
    if (!in_range)                kind = K_NONE;
    else if (word == MAP.limit_i) kind = K_LIMIT;
    else if (word == MAP.prod_i)  kind = K_PROD;
    else if (word == MAP.cons_i)  kind = K_CONS;
    else if (word == MAP.ena_i)   kind = K_ENA;
    else if (word == MAP.sts_i)   kind = K_STS;
    else                          kind = K_PLAIN;
  end

endmodule

// File: rtl/cq_word_store.sv
module cq_word_store
  import cq_regif_pkg::*;
#(
  parameter int MAP_SEL   = 0,
  parameter int NUM_WORDS = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                a_en,
  input  logic [$clog2(NUM_WORDS)-1:0]        a_idx,
  input  logic [DATA_W-1:0]                   a_data,
  input  logic                                b_en,
  input  logic [$clog2(NUM_WORDS)-1:0]        b_idx,
  input  logic [DATA_W-1:0]                   b_data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    words
);

  localparam int   IDX_W = $clog2(NUM_WORDS);
  localparam map_t MAP   = map_of(MAP_SEL);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == int'(MAP.ena_i) || i == int'(MAP.sts_i)) begin : g_hole
      // enable and status live in the event controller
      assign words[i] = '0;
    end else begin : g_reg
      logic              hit_a;
      logic              hit_b;
      logic              word_en;
      logic [DATA_W-1:0] word_d;
      logic [DATA_W-1:0] word_q;

      assign hit_a   = a_en && (a_idx == IDX_W'(i));
      assign hit_b   = b_en && (b_idx == IDX_W'(i));
      assign word_en = hit_a || hit_b;

      always_comb begin
        word_d = word_q;
        if (hit_b)      word_d = b_data;
        else if (hit_a) word_d = a_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (word_en) word_q <= word_d;
      end

      assign words[i] = word_q;
    end
  end

endmodule

// File: rtl/cq_event_ctrl.sv
module cq_event_ctrl
  import cq_regif_pkg::*;
#(
  parameter int MAP_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  kind_e             kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ena_q,
  output logic [DATA_W-1:0] sts_q,
  output logic              irq_q
);

  localparam map_t MAP = map_of(MAP_SEL);

  logic              armed_q;
  logic              armed_d;
  logic [DATA_W-1:0] ena_d;
  logic [DATA_W-1:0] sts_d;
  logic              irq_d;

  always_comb begin
    ena_d   = ena_q;
    sts_d   = sts_q;
    irq_d   = irq_q;
    armed_d = armed_q;
    unique case (kind)
      K_ENA: ena_d = wdata & MAP.ena_mask;
      K_CONS: begin
        if (wdata == ARM_KEY) armed_d = 1'b1;
      end
      K_PROD: begin
        if (armed_q) begin
          armed_d = 1'b0;
        end else begin
          sts_d = sts_q | MAP.done_mask;
          if ((ena_q & MAP.done_mask) != '0) irq_d = 1'b1;
        end
      end
      K_STS: begin
        if ((wdata & MAP.done_mask) != '0) begin
          sts_d = sts_q & ~MAP.done_mask;
          irq_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q   <= '0;
      sts_q   <= STS_RESET;
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (wr_acc) begin
      ena_q   <= ena_d;
      sts_q   <= sts_d;
      irq_q   <= irq_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/cq_regif.sv
module cq_regif
  import cq_regif_pkg::*;
#(
  parameter int MAP_SEL   = 0,
  parameter int NUM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int   IDX_W = $clog2(NUM_WORDS);
  localparam map_t MAP   = map_of(MAP_SEL);

  logic                             rst_sync_n;
  logic                             in_range;
  logic [IDX_W-1:0]                 idx;
  kind_e                            kind;
  logic                             wr_acc;
  logic                             a_en;
  logic                             b_en;
  logic [DATA_W-1:0]                ptr_val;
  logic [DATA_W-1:0]                a_data;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]                ena_q;
  logic [DATA_W-1:0]                sts_q;
  logic [DATA_W-1:0]                sel_word;
  logic                             rd_en;
  logic [DATA_W-1:0]                rdata_d;
  logic [DATA_W-1:0]                rdata_q;
  logic [DATA_W-1:0]                prod_word;
  logic [DATA_W-1:0]                cons_word;

  cq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cq_addr_decode #(.MAP_SEL(MAP_SEL), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr     (bus_addr),
    .in_range (in_range),
    .idx      (idx),
    .kind     (kind)
  );

  assign wr_acc  = bus_valid && bus_write && in_range;
  assign ptr_val = {{(DATA_W-PTR_W){1'b0}}, bus_wdata[PTR_W-1:0]};
  assign a_en    = wr_acc && (kind == K_PLAIN || kind == K_LIMIT || kind == K_PROD);
  assign a_data  = (kind == K_PLAIN) ? bus_wdata : ptr_val;
  assign b_en    = wr_acc && (kind == K_PROD);

  cq_word_store #(.MAP_SEL(MAP_SEL), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .a_en   (a_en),
    .a_idx  (idx),
    .a_data (a_data),
    .b_en   (b_en),
    .b_idx  (MAP.cons_i[IDX_W-1:0]),
    .b_data (ptr_val),
    .words  (words)
  );

  cq_event_ctrl #(.MAP_SEL(MAP_SEL)) u_evt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_acc (wr_acc),
    .kind   (kind),
    .wdata  (bus_wdata),
    .ena_q  (ena_q),
    .sts_q  (sts_q),
    .irq_q  (irq)
  );

  assign prod_word = words[MAP.prod_i[IDX_W-1:0]];
  assign cons_word = words[MAP.cons_i[IDX_W-1:0]];

  always_comb begin
    unique case (kind)
      K_ENA:   sel_word = ena_q;
      K_STS:   sel_word = sts_q;
      K_NONE:  sel_word = '0;
      default: sel_word = words[idx];
    endcase
  end

  assign rd_en   = bus_valid && !bus_write;
  assign rdata_d = sel_word;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_en)   rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/cq_regif_chk.sv
module cq_regif_chk
  import cq_regif_pkg::*;
#(
  parameter int MAP_SEL   = 0,
  parameter int NUM_WORDS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] prod_word,
  input logic [DATA_W-1:0] cons_word,
  input logic [DATA_W-1:0] sts_q
);

  localparam map_t MAP = map_of(MAP_SEL);

  logic [WORD_AW-1:0] word;
  logic               wr_prod;
  logic               wr_cons;
  logic               wr_clear;
  logic               rd_out;

  assign word     = bus_addr[ADDR_W-1:2];
  assign wr_prod  = bus_valid && bus_write && (word == MAP.prod_i);
  assign wr_cons  = bus_valid && bus_write && (word == MAP.cons_i);
  assign wr_clear = bus_valid && bus_write && (word == MAP.sts_i)
                    && ((bus_wdata & MAP.done_mask) != '0);
  assign rd_out   = bus_valid && !bus_write && (word >= WORD_AW'(NUM_WORDS));

  // R7 / R11: irq only rises as the result of a producer-pointer write
  p_irq_rise_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_prod));

  // R9: a clearing status write drops irq and both completion bits
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> (!irq && ((sts_q & MAP.done_mask) == '0)));

  // R9: non-completion status bits keep their reset value
  p_sts_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~MAP.done_mask) == STS_RESET);

  // R5: consumer pointer mirrors producer pointer after a producer write
  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prod |=> (cons_word == prod_word));

  // R6: consumer-address writes leave the consumer pointer unchanged
  p_cons_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cons |=> $stable(cons_word));

  // R3: reads beyond the implemented words return zero
  p_oor_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |=> (bus_rdata == '0));

  // R12: the newer layout never asserts irq
  p_newer_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (MAP_SEL != 0) |-> !irq);

endmodule

bind cq_regif cq_regif_chk #(.MAP_SEL(MAP_SEL), .NUM_WORDS(NUM_WORDS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .prod_word (prod_word),
  .cons_word (cons_word),
  .sts_q     (sts_q)
);

// File: tb/cq_regif_tb_top.sv
module cq_regif_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [31:0] KEY = 32'hEE88_2266;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v0 = 1'b0;
  logic        v1 = 1'b0;
  logic        w = 1'b0;
  logic [11:0] a = '0;
  logic [31:0] d = '0;
  logic [31:0] rd0;
  logic [31:0] rd1;
  logic        irq0;
  logic        irq1;

  int ntests = 0;
  int nfail  = 0;

  int          q_tgt[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic        pend = 1'b0;
  logic        pend_t = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cq_regif #(.MAP_SEL(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(v0), .bus_write(w),
    .bus_addr(a), .bus_wdata(d), .bus_rdata(rd0), .irq(irq0)
  );

  cq_regif #(.MAP_SEL(1)) dut_n_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(v1), .bus_write(w),
    .bus_addr(a), .bus_wdata(d), .bus_rdata(rd1), .irq(irq1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int t, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    v0 = (t == 0); v1 = (t == 1); w = 1'b1; a = addr; d = data;
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0; w = 1'b0;
  endtask

  task automatic rd(input int t, input logic [11:0] addr, input logic [31:0] exp,
                    input string tag);
    @(negedge clk);
    v0 = (t == 0); v1 = (t == 1); w = 1'b0; a = addr;
    q_tgt.push_back(t); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor: a read accepted at an edge is compared one half cycle later
  always @(posedge clk) begin
    pend   <= (v0 || v1) && !w;
    pend_t <= v1;
  end

  always @(negedge clk) begin
    if (pend) begin
      if (q_exp.size() == 0) begin
        ntests++; nfail++;
        $display("FAIL scoreboard underflow actual=%h expected=none", pend_t ? rd1 : rd0);
      end else begin
        int          t;
        logic [31:0] e;
        string       tg;
        t  = q_tgt.pop_front();
        e  = q_exp.pop_front();
        tg = q_tag.pop_front();
        chk(tg, (t == 1) ? rd1 : rd0, e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 irq low in reset", {31'd0, irq0}, 32'd0);
    do_reset();
    chk("R1 irq after reset", {31'd0, irq0}, 32'd0);
    chk("R1 newer irq after reset", {31'd0, irq1}, 32'd0);
    rd(0, 12'h024, 32'hF800_0000, "R1 status reset");
    rd(0, 12'h020, 32'h0, "R1 enable reset");
    rd(0, 12'h018, 32'h0, "R1 producer reset");
    rd(1, 12'h03C, 32'hF800_0000, "R1 newer status reset");

    wr(0, 12'h000, 32'hDEAD_BEEF);
    wr(0, 12'h07C, 32'h1234_5678);
    wr(0, 12'h040, 32'hA5A5_5A5A);
    rd(0, 12'h000, 32'hDEAD_BEEF, "R2 word 0");
    rd(0, 12'h07C, 32'h1234_5678, "R2 last word");
    rd(0, 12'h040, 32'hA5A5_5A5A, "R2 middle word");

    wr(0, 12'h080, 32'hFFFF_FFFF);
    rd(0, 12'h080, 32'h0, "R3 first outside word");
    rd(0, 12'hFFC, 32'h0, "R3 top of window");
    rd(0, 12'h000, 32'hDEAD_BEEF, "R3 no alias write");

    wr(0, 12'h014, 32'hFFFF_FFFF);
    rd(0, 12'h014, 32'h0003_FFFF, "R4 limit mask");
    wr(0, 12'h018, 32'hABCD_E123);
    rd(0, 12'h018, 32'h0001_E123, "R4 producer mask");
    rd(0, 12'h01C, 32'h0001_E123, "R5 mirror");
    rd(0, 12'h024, 32'hF800_0030, "R7 status bits set");
    chk("R7 irq stays low when disabled", {31'd0, irq0}, 32'd0);

    wr(0, 12'h01C, 32'h0000_0555);
    rd(0, 12'h01C, 32'h0001_E123, "R6 consumer unchanged");

    wr(0, 12'h020, 32'hFFFF_FFFF);
    rd(0, 12'h020, 32'hBFEF_F07F, "R8 legacy enable mask");

    wr(0, 12'h024, 32'h0000_0010);
    rd(0, 12'h024, 32'hF800_0000, "R9 clear by one bit");

    wr(0, 12'h018, 32'h0000_0005);
    chk("R7 irq raised", {31'd0, irq0}, 32'd1);
    rd(0, 12'h024, 32'hF800_0030, "R7 status after enabled completion");
    rd(0, 12'h01C, 32'h0000_0005, "R5 mirror second");

    wr(0, 12'h024, 32'h0000_000F);
    chk("R9 non-clearing write keeps irq", {31'd0, irq0}, 32'd1);
    rd(0, 12'h024, 32'hF800_0030, "R9 non-clearing write");
    wr(0, 12'h024, 32'hFFFF_FFFF);
    chk("R9 irq dropped", {31'd0, irq0}, 32'd0);
    rd(0, 12'h024, 32'hF800_0000, "R9 other bits kept");

    wr(0, 12'h020, 32'h0000_0020);
    wr(0, 12'h018, 32'h0000_0006);
    chk("R7 single enable bit", {31'd0, irq0}, 32'd1);

    wr(0, 12'h020, 32'h0000_0000);
    chk("R11 enable cleared irq held", {31'd0, irq0}, 32'd1);
    wr(0, 12'h004, 32'h0000_0001);
    chk("R11 plain write irq held", {31'd0, irq0}, 32'd1);
    wr(0, 12'h018, 32'h0000_0007);
    chk("R11 disabled completion irq held", {31'd0, irq0}, 32'd1);
    wr(0, 12'h024, 32'h0000_0020);
    chk("R9 clear by other bit", {31'd0, irq0}, 32'd0);

    wr(0, 12'h020, 32'h0000_0030);
    wr(0, 12'h01C, KEY);
    wr(0, 12'h01C, 32'h0000_1234);
    wr(0, 12'h018, 32'h0000_0022);
    chk("R10 suppressed no irq", {31'd0, irq0}, 32'd0);
    rd(0, 12'h024, 32'hF800_0000, "R10 suppressed no status");
    rd(0, 12'h018, 32'h0000_0022, "R10 producer stored");
    rd(0, 12'h01C, 32'h0000_0022, "R10 mirror while suppressed");
    wr(0, 12'h018, 32'h0000_0033);
    chk("R10 one-shot only", {31'd0, irq0}, 32'd1);
    rd(0, 12'h024, 32'hF800_0030, "R10 next completion status");
    wr(0, 12'h024, 32'h0000_0030);

    wr(0, 12'h01C, KEY);
    do_reset();
    chk("R1 irq after second reset", {31'd0, irq0}, 32'd0);
    rd(0, 12'h000, 32'h0, "R1 plain cleared");
    wr(0, 12'h020, 32'h0000_0030);
    wr(0, 12'h018, 32'h0000_0001);
    chk("R1 flag cleared by reset", {31'd0, irq0}, 32'd1);

    wr(1, 12'h038, 32'hFFFF_FFFF);
    rd(1, 12'h038, 32'h0170_03FF, "R8 newer enable mask");
    wr(1, 12'h01C, 32'hFFFF_FFFF);
    rd(1, 12'h01C, 32'h0003_FFFF, "R12 newer producer");
    rd(1, 12'h020, 32'h0003_FFFF, "R12 newer consumer mirror");
    rd(1, 12'h03C, 32'hF803_0000, "R12 newer completion bits");
    chk("R12 newer irq never", {31'd0, irq1}, 32'd0);
    wr(1, 12'h014, 32'hFFFF_FFFF);
    rd(1, 12'h014, 32'hFFFF_FFFF, "R12 newer 0x14 plain");
    wr(1, 12'h018, 32'hFFFF_FFFF);
    rd(1, 12'h018, 32'h0003_FFFF, "R12 newer limit mask");
    wr(1, 12'h03C, 32'h0001_0000);
    rd(1, 12'h03C, 32'hF800_0000, "R9 newer clear");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      ntests++; nfail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q_exp.size());
    end
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule